// File: doc/BRIEF.md
# Parallel IQ Sample Interleaver

The block accepts one in-phase word and one quadrature word per sample period and sends both over one parallel bus whose width equals a single sample word. A programmed order bit decides whether the in-phase or the quadrature word leaves first. The clocks-per-sample value sets how many clock periods one sample period lasts. At one clock per sample, the two words share one clock period. The first word is on the bus while the clock is high and the second while it is low, so the pair rate equals the clock rate.

Pairs enter through a valid/ready handshake. Ready is high only in the last clock of a period. If no pair is offered there, the previous pair is sent again and an underrun flag is raised. Order and rate are captured only together with a new period, so a pair is never split across two settings. When the interface is configured as an input, the rate is forced to one clock per sample.

Top module: `iq_interleaver`

## Requirements
- R1: With `order_qi` = 0 the in-phase word is driven first on `out_data` and the quadrature word second, both on the same bus.
- R2: With `order_qi` = 1 the quadrature word is driven first and the in-phase word second.
- R3: For a clocks-per-sample value N > 1, a period lasts N clocks. The first word is held for floor(N/2) clocks and the second for the remaining clocks, so an odd N gives the extra clock to the second word. `out_first` is 1 exactly while the first word is driven.
- R4: For N = 1, and for a programmed value of 0, the first word is driven while `clk` is high and the second while `clk` is low. A new pair is taken every clock, and `out_first` follows `clk`.
- R5: With `dir_input` = 1 the block runs at one clock per sample whatever value `cps` holds.
- R6: `in_ready` is 1 only in the last clock of a period. A pair is taken at the rising edge that ends that clock when `in_valid` is 1, and exactly one pair is taken per period.
- R7: Changes to `order_qi`, `cps`, `dir_input` or the input words in the middle of a period do not affect the period under way.
- R8: If `in_valid` is 0 at the end of a period, the next period repeats the previous pair in the previous order and `underrun` is 1 throughout it. A period that starts with an accepted pair has `underrun` at 0.
- R9: A synchronous reset drives `out_data` to 0 and `underrun` to 0. It leaves the block at a period boundary with `in_ready` = 1, so the next accepted pair starts a fresh period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges carry data at one clock per sample |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An I/Q pair is offered |
| in_ready | output | 1 | Last clock of the period; a pair may be taken |
| in_i | input | W | In-phase word |
| in_q | input | W | Quadrature word |
| order_qi | input | 1 | 0: in-phase first, 1: quadrature first |
| cps | input | CPS_W | Clocks per sample period (0 is treated as 1) |
| dir_input | input | 1 | Input direction; forces one clock per sample |
| out_data | output | W | Interleaved sample bus |
| out_first | output | 1 | Bus carries the first word of the pair |
| underrun | output | 1 | The current period repeats the previous pair |

## Verification
The period-boundary handshake and a change of settings can land in the same cycle. They can also land one cycle apart, with the change arriving mid-period. The bench moves order, rate and data one clock after a pair is taken. It checks that the rest of that period keeps the old split and order, and that the next boundary takes all of them together. It also withdraws `in_valid` exactly at a boundary and asserts reset in the middle of a long period. For each case it compares the repeated pair, the underrun flag and the restart position against values derived from the requirements.

// File: rtl/iq_ilv_pkg.sv
package iq_ilv_pkg;

    typedef enum logic {
        ORD_IQ = 1'b0,
        ORD_QI = 1'b1
    } order_e;

    // Effective period length in clocks: input direction and a zero setting both give one.
    function automatic int unsigned eff_cps(input int unsigned raw, input logic force_one);
        if (force_one || raw == 0) begin
            return 1;
        end
        return raw;
    endfunction

endpackage

// File: rtl/iq_ilv_timer.sv
module iq_ilv_timer #(
    parameter int CPS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CPS_W-1:0] next_len,
    output logic             boundary,
    output logic             first_half,
    output logic             dual_edge
);
    logic [CPS_W-1:0] cnt_d, cnt_q;
    logic [CPS_W-1:0] len_d, len_q;

    assign boundary   = (cnt_q == len_q - CPS_W'(1));
    assign first_half = (cnt_q < (len_q >> 1));
    assign dual_edge  = (len_q == CPS_W'(1));

    always_comb begin
        cnt_d = cnt_q + CPS_W'(1);
        len_d = len_q;
        if (boundary) begin
            cnt_d = '0;
            len_d = next_len;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            len_q <= CPS_W'(1);
        end else begin
            cnt_q <= cnt_d;
            len_q <= len_d;
        end
    end
endmodule

// File: rtl/iq_ilv_order.sv
module iq_ilv_order
    import iq_ilv_pkg::*;
#(
    parameter int W = 4
) (
    input  order_e         order,
    input  logic [W-1:0]   word_i,
    input  logic [W-1:0]   word_q,
    output logic [W-1:0]   lead,
    output logic [W-1:0]   trail
);
    always_comb begin
        if (order == ORD_QI) begin
            lead  = word_q;
            trail = word_i;
        end else begin
            lead  = word_i;
            trail = word_q;
        end
    end
endmodule

// File: rtl/iq_ilv_outmux.sv
module iq_ilv_outmux #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         dual_edge,
    input  logic         first_half,
    input  logic [W-1:0] lead,
    input  logic [W-1:0] trail,
    output logic [W-1:0] bus,
    output logic         on_lead
);
    // One clock per sample: clock level picks the word, so each edge starts a new word.
    always_comb begin
        on_lead = dual_edge ? clk : first_half;
        bus     = on_lead ? lead : trail;
    end
endmodule

// File: rtl/iq_interleaver.sv
module iq_interleaver
    import iq_ilv_pkg::*;
#(
    parameter int W     = 4,
    parameter int CPS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [W-1:0]     in_i,
    input  logic [W-1:0]     in_q,
    input  logic             order_qi,
    input  logic [CPS_W-1:0] cps,
    input  logic             dir_input,
    output logic [W-1:0]     out_data,
    output logic             out_first,
    output logic             underrun
);
    typedef struct packed {
        logic [W-1:0] lead;
        logic [W-1:0] trail;
        logic         underrun;
    } pair_t;

    pair_t state_d, state_q;

    logic             boundary, first_half, dual_edge;
    logic [CPS_W-1:0] eff_len;
    logic [W-1:0]     ord_lead, ord_trail;
    logic [W-1:0]     lead_w, trail_w;

    assign eff_len = CPS_W'(eff_cps(int'(unsigned'(cps)), dir_input));

    iq_ilv_timer #(.CPS_W(CPS_W)) timer_i (
        .clk        (clk),
        .rst        (rst),
        .next_len   (eff_len),
        .boundary   (boundary),
        .first_half (first_half),
        .dual_edge  (dual_edge)
    );

    iq_ilv_order #(.W(W)) order_i (
        .order  (order_e'(order_qi)),
        .word_i (in_i),
        .word_q (in_q),
        .lead   (ord_lead),
        .trail  (ord_trail)
    );

    always_comb begin
        state_d = state_q;
        if (boundary) begin
            if (in_valid) begin
                state_d.lead     = ord_lead;
                state_d.trail    = ord_trail;
                state_d.underrun = 1'b0;
            end else begin
                state_d.underrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lead_w   = state_q.lead;
    assign trail_w  = state_q.trail;
    assign in_ready = boundary;
    assign underrun = state_q.underrun;

    iq_ilv_outmux #(.W(W)) outmux_i (
        .clk        (clk),
        .dual_edge  (dual_edge),
        .first_half (first_half),
        .lead       (lead_w),
        .trail      (trail_w),
        .bus        (out_data),
        .on_lead    (out_first)
    );
endmodule

// File: rtl/iq_interleaver_chk.sv
module iq_interleaver_chk #(
    parameter int W     = 4,
    parameter int CPS_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [CPS_W-1:0] cps,
    input logic             dir_input,
    input logic [W-1:0]     out_data,
    input logic             underrun,
    input logic [W-1:0]     held_lead,
    input logic [W-1:0]     held_trail
);
    assert_underrun_set_R8: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> underrun);

    assert_underrun_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_valid) |=> !underrun);

    assert_pair_held_R7: assert property (@(posedge clk) disable iff (rst)
        (!in_ready) |=> ($stable(held_lead) && $stable(held_trail)));

    assert_one_per_period_R6: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !dir_input && cps > CPS_W'(1)) |=> !in_ready);

    assert_input_forces_one_R5: assert property (@(posedge clk) disable iff (rst)
        (in_ready && dir_input) |=> in_ready);

    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (out_data == '0 && !underrun && in_ready));
endmodule

bind iq_interleaver iq_interleaver_chk #(.W(W), .CPS_W(CPS_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .cps        (cps),
    .dir_input  (dir_input),
    .out_data   (out_data),
    .underrun   (underrun),
    .held_lead  (lead_w),
    .held_trail (trail_w)
);

// File: tb/iq_interleaver_tb.sv
module iq_interleaver_tb_top;
    localparam int W     = 4;
    localparam int CPS_W = 4;
    localparam int P     = 10;
    localparam int NV    = 8;
    // {cps, order_qi, in_i, in_q}
    localparam int VEC [NV][4] = '{
        '{1, 0, 3, 12}, '{1, 1, 5, 10}, '{2, 0, 1, 2}, '{3, 1, 7, 8},
        '{4, 0, 9, 6},  '{5, 1, 15, 0}, '{0, 0, 11, 4}, '{6, 0, 13, 14}
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic             in_ready;
    logic [W-1:0]     in_i, in_q;
    logic             order_qi;
    logic [CPS_W-1:0] cps;
    logic             dir_input;
    logic [W-1:0]     out_data;
    logic             out_first;
    logic             underrun;

    int n_cmp = 0;
    int n_err = 0;
    bit done  = 0;

    always #(P/2) clk = ~clk;

    iq_interleaver #(.W(W), .CPS_W(CPS_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .order_qi(order_qi), .cps(cps),
        .dir_input(dir_input), .out_data(out_data), .out_first(out_first),
        .underrun(underrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input int c, input int o, input int i, input int q,
                         input bit v, input bit d);
        cps = CPS_W'(c); order_qi = o[0]; in_i = W'(i); in_q = W'(q);
        in_valid = v; dir_input = d;
    endtask

    // Called 3P/4 after an edge; checks clocks k0..n-1 of a period, returns 3P/4 after the last edge.
    task automatic span(input int f, input int s, input int n, input int k0,
                        input int unr, input string req);
        for (int k = k0; k < n; k++) begin
            @(posedge clk);
            #(P/4);
            if (n == 1) begin
                chk(req, int'(out_data), f);
                chk(req, int'(out_first), 1);
            end else begin
                chk(req, int'(out_data), (k < n/2) ? f : s);
                chk(req, int'(out_first), (k < n/2) ? 1 : 0);
            end
            chk({req, " underrun"}, int'(underrun), unr);
            #(P/2);
            if (n == 1) begin
                chk(req, int'(out_data), s);
                chk(req, int'(out_first), 0);
            end
            chk({req, " R6 ready"}, int'(in_ready), (k == n-1) ? 1 : 0);
        end
    endtask

    initial begin
        #(P*4000);
        if (!done) begin
            n_cmp++; n_err++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #(P/4);
        chk("R9 reset data", int'(out_data), 0);
        chk("R9 reset underrun", int'(underrun), 0);
        chk("R9 reset ready", int'(in_ready), 1);
        #(P/2);
        chk("R9 reset data low", int'(out_data), 0);
        rst = 1'b0;

        // Table walk: R1/R2 order, R3 multi-clock split, R4 dual-edge (cps 1 and 0)
        for (int v = 0; v < NV; v++) begin
            int n;
            int f;
            int s;
            string req;
            n = (VEC[v][0] == 0) ? 1 : VEC[v][0];
            f = VEC[v][1] ? VEC[v][3] : VEC[v][2];
            s = VEC[v][1] ? VEC[v][2] : VEC[v][3];
            req = (n == 1) ? "R4" : "R3";
            req = {req, VEC[v][1] ? " R2" : " R1"};
            drive(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1, 0);
            span(f, s, n, 0, 0, req);
        end

        // R7: settings and data change one clock into a 4-clock IQ period
        drive(4, 0, 2, 9, 1, 0);
        @(posedge clk);
        #(P/4);
        chk("R7 first clock", int'(out_data), 2);
        #(P/2);
        drive(2, 1, 6, 3, 1, 0);
        span(2, 9, 4, 1, 0, "R7 old period");
        span(3, 6, 2, 0, 0, "R7 new period R2");

        // R8: withdraw valid at the boundary, previous pair and order repeat
        in_valid = 1'b0;
        span(3, 6, 2, 0, 1, "R8 repeat");
        drive(2, 0, 10, 5, 1, 0);
        span(10, 5, 2, 0, 0, "R8 recover");

        // R5: input direction forces one clock per sample
        drive(7, 0, 12, 1, 1, 1);
        span(12, 1, 1, 0, 0, "R5 IQ");
        drive(3, 1, 4, 8, 1, 1);
        span(8, 4, 1, 0, 0, "R5 QI");

        // R9: reset in the middle of a 6-clock period
        drive(6, 0, 14, 7, 1, 0);
        @(posedge clk);
        #(P/4);
        chk("R9 before reset", int'(out_data), 14);
        #(P/2);
        rst = 1'b1;
        @(posedge clk);
        #(P/4);
        chk("R9 mid reset data", int'(out_data), 0);
        chk("R9 mid reset underrun", int'(underrun), 0);
        chk("R9 mid reset ready", int'(in_ready), 1);
        #(P/2);
        rst = 1'b0;
        drive(2, 1, 1, 13, 1, 0);
        span(13, 1, 2, 0, 0, "R9 restart");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule